// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into a serial frame on a single transmit line. A character enters through a valid/ready handshake and is held inside the block until every bit of its frame has left. The frame is framed by a low start bit and a high stop bit. An even parity bit may be placed between the data and the stop bit. Static configuration inputs choose the bit order, whether a parity bit is sent, and whether the data bits go out complemented.

Bit timing comes from an external baud tick. In asynchronous mode each tick ends one bit and starts the next. In synchronous mode the block also drives a shift clock: every tick toggles that clock, so one bit lasts two ticks. The polarity setting fixes the level the clock rests at and which of its edges launches new data. The configuration is captured together with the character, so the frame already on the line is not disturbed by later changes. A one-cycle completion pulse marks the end of each frame. A new character can be accepted in that same cycle.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset `txd` is 1, `in_ready` is 1 and `tx_done` is 0. While idle, `xck` equals `cfg_pol`.
- R2: A character is taken in the cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from the next cycle until the frame ends. A valid offered while busy is ignored and does not alter the frame.
- R3: A frame is sent LSB-of-list first, as follows: a start bit of 0, eight data bits, an even parity bit only when `cfg_parity`=1, then a stop bit of 1. This gives 11 bit periods with parity and 10 without.
- R4: With `cfg_lsb_first`=0, data bit 7 is sent first and bit 0 last. With `cfg_lsb_first`=1, bit 0 is sent first and bit 7 last.
- R5: With `cfg_inv`=1 every data bit is sent complemented. The start, parity and stop bits keep their normal levels.
- R6: The parity bit is the XOR of the eight data bits as they appear on the line, that is, after inversion.
- R7: With `cfg_sync`=0, `txd` changes only in the cycle after a sampled `baud_tick`. The start bit appears after the first tick that follows acceptance. Each following tick moves the line to the next bit.
- R8: With `cfg_sync`=1, each tick during a frame toggles `xck`, so a bit lasts two ticks. `txd` changes only on the ticks that move `xck` away from `cfg_pol`. This is the rising edge for polarity 0 and the falling edge for polarity 1. On the other ticks `xck` returns to `cfg_pol` and `txd` holds.
- R9: The tick that ends the stop bit period raises `tx_done` for exactly one cycle, in the cycle after that tick. In that same cycle `in_ready` is 1, `txd` is 1 and `xck` equals `cfg_pol`.
- R10: The configuration inputs are captured at acceptance. Changing them during a frame has no effect on that frame's bits or clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lsb_first | input | 1 | 1: data bit 0 sent first; 0: data bit 7 first |
| cfg_pol | input | 1 | Shift clock idle level and launch-edge select |
| cfg_sync | input | 1 | 0: asynchronous; 1: synchronous with shift clock |
| cfg_parity | input | 1 | 1: append even parity bit |
| cfg_inv | input | 1 | 1: complement the data bits on the line |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle and able to take a character |
| baud_tick | input | 1 | One-cycle bit-timing strobe |
| txd | output | 1 | Serial transmit line, idles high |
| xck | output | 1 | Shift clock for synchronous mode |
| tx_done | output | 1 | One-cycle pulse after the stop bit ends |

## Verification
The completion pulse of one frame and the acceptance of the next character can fall in the same cycle, because `in_ready` rises together with `tx_done`. The bench provokes this by raising `in_valid` with a fresh character just before the tick that ends the stop bit. It then checks three things: that both `tx_done` and `in_ready` are high in the pulse cycle, that the handshake completes on the next edge, and that the following frame carries the new character bit for bit. The sweep also overlaps a busy-time valid pulse and a configuration change with a frame in flight. It judges from the line that neither leaked into the frame.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef struct packed {
    logic lsb_first;
    logic pol;
    logic sync;
    logic parity;
    logic inv;
  } tx_cfg_t;
endpackage

// File: rtl/sft_framer.sv
module sft_framer #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  sft_pkg::tx_cfg_t   cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  // Position 0 of the result leaves the line first.
  function automatic logic [DATA_W-1:0] line_order(input logic [DATA_W-1:0] d,
                                                   input logic lsb_first);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = lsb_first ? d[i] : d[DATA_W-1-i];
    return r;
  endfunction

  function automatic logic even_par(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  logic [DATA_W-1:0] wire_bits;
  assign wire_bits = data_i ^ {DATA_W{cfg_i.inv}};

  always_comb begin
    frame_o                = '1;
    frame_o[0]             = 1'b0;
    frame_o[DATA_W:1]      = line_order(wire_bits, cfg_i.lsb_first);
    if (cfg_i.parity) begin
      frame_o[DATA_W+1] = even_par(wire_bits);
      nbits_o           = CNT_W'(DATA_W + 3);
    end else begin
      nbits_o           = CNT_W'(DATA_W + 2);
    end
  end
endmodule

// File: rtl/sft_pacer.sv
module sft_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic sync_i,
  input  logic tick_i,
  input  logic last_i,
  output logic launch_o,
  output logic finish_o,
  output logic phase_o
);
  logic phase_q;
  logic boundary;

  // A bit boundary: every tick in asynchronous mode, every other tick in synchronous mode.
  assign boundary = tick_i && busy_i && (!sync_i || !phase_q);
  assign launch_o = boundary && !last_i;
  assign finish_o = boundary && last_i;
  assign phase_o  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= 1'b0;
    else if (tick_i && busy_i && sync_i && !finish_o)
      phase_q <= ~phase_q;
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               launch_i,
  input  logic               finish_i,
  output logic               txd_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               last_o,
  output logic               at_start_o
);
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nbits_q;

  assign last_o     = (cnt_q == nbits_q);
  assign at_start_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '1;
      cnt_q   <= '0;
      nbits_q <= '0;
      txd_o   <= 1'b1;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        sreg_q  <= frame_i;
        nbits_q <= nbits_i;
        cnt_q   <= '0;
        busy_o  <= 1'b1;
      end else if (launch_i) begin
        txd_o  <= sreg_q[0];
        sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
        cnt_q  <= cnt_q + 1'b1;
      end else if (finish_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        txd_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_pol,
  input  logic              cfg_sync,
  input  logic              cfg_parity,
  input  logic              cfg_inv,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  output logic              txd,
  output logic              xck,
  output logic              tx_done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sft_pkg::tx_cfg_t cfg_live, cfg_q;
  logic busy, load, launch, finish, last, phase, at_start;
  logic sync_q, pol_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign cfg_live = '{lsb_first: cfg_lsb_first, pol: cfg_pol, sync: cfg_sync,
                      parity: cfg_parity, inv: cfg_inv};
  assign in_ready = !busy;
  assign load     = in_valid && in_ready;
  assign sync_q   = cfg_q.sync;
  assign pol_q    = cfg_q.pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (load)
      cfg_q <= cfg_live;
  end

  sft_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data_i (in_data),
    .cfg_i  (cfg_live),
    .frame_o(frame),
    .nbits_o(nbits)
  );

  sft_pacer u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy),
    .sync_i  (sync_q),
    .tick_i  (baud_tick),
    .last_i  (last),
    .launch_o(launch),
    .finish_o(finish),
    .phase_o (phase)
  );

  sft_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .frame_i   (frame),
    .nbits_i   (nbits),
    .launch_i  (launch),
    .finish_i  (finish),
    .txd_o     (txd),
    .busy_o    (busy),
    .done_o    (tx_done),
    .last_o    (last),
    .at_start_o(at_start)
  );

  assign xck = busy ? (pol_q ^ phase) : cfg_pol;
endmodule

// File: rtl/sft_checks.sv
module sft_checks (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic launch,
  input logic finish,
  input logic at_start,
  input logic sync_q,
  input logic pol_q,
  input logic in_ready,
  input logic txd,
  input logic xck,
  input logic tx_done
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);                                             // R1
  AST_TXD_ONLY_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch) |=> $stable(txd));                           // R7
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && at_start) |=> !txd);                                // R3
  AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sync_q) |=> (xck != pol_q));                        // R8
  AST_DONE_FOLLOWS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (tx_done && in_ready));                             // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);                                         // R9
endmodule

bind serial_frame_tx sft_checks u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .launch  (launch),
  .finish  (finish),
  .at_start(at_start),
  .sync_q  (sync_q),
  .pol_q   (pol_q),
  .in_ready(in_ready),
  .txd     (txd),
  .xck     (xck),
  .tx_done (tx_done)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lsb_first = 0, cfg_pol = 0, cfg_sync = 0, cfg_parity = 0, cfg_inv = 0;
  logic [7:0] in_data = '0;
  logic in_valid = 0, baud_tick = 0;
  logic in_ready, txd, xck, tx_done;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_frame_tx #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first), .cfg_pol(cfg_pol),
    .cfg_sync(cfg_sync), .cfg_parity(cfg_parity), .cfg_inv(cfg_inv),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .baud_tick(baud_tick), .txd(txd), .xck(xck), .tx_done(tx_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void put_cfg(input logic [4:0] c);
    {cfg_lsb_first, cfg_pol, cfg_sync, cfg_parity, cfg_inv} = c;
  endfunction

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  // c = {lsb_first, pol, sync, parity, inv}
  task automatic send(input logic [7:0] d, input logic [4:0] c, input bit preloaded,
                      input bit chain, input logic [7:0] nd);
    logic exp [0:10];
    int nb;
    logic [7:0] dv;
    logic lsb, pol, syn, par, inv;
    string tag;
    {lsb, pol, syn, par, inv} = c;
    dv = d ^ {8{inv}};
    exp[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp[1+i] = lsb ? dv[i] : dv[7-i];
    if (par) begin exp[9] = ^dv; exp[10] = 1'b1; nb = 11; end
    else begin exp[9] = 1'b1; exp[10] = 1'b1; nb = 10; end
    if (!preloaded) begin
      put_cfg(c);
      in_data = d; in_valid = 1'b1;
      @(negedge clk) in_valid = 1'b0;
      chk("R2 ready low after accept", in_ready, 0);
      chk("R7 line idle before first tick", txd, 1);
    end
    // R10: configuration changed mid-frame; R2: valid offered while busy
    put_cfg(~c);
    in_data = ~d; in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    chk("R2 busy ignores valid", in_ready, 0);
    for (int k = 0; k < nb; k++) begin
      tick();
      if (k == 0 || k == nb - 1) tag = "R3 start/stop";
      else if (par && k == 9) tag = "R6 parity";
      else if (inv) tag = "R5 inverted data";
      else tag = "R4 data order";
      chk(tag, txd, exp[k]);
      if (syn) begin
        chk("R8 launch edge", xck, !pol);
        tick();
        chk("R8 sample edge", xck, pol);
        chk("R8 hold on sample edge", txd, exp[k]);
      end else begin
        @(negedge clk);
        chk("R7 stable between ticks", txd, exp[k]);
        chk("R10 xck unaffected", xck, pol);
      end
    end
    put_cfg(c);
    if (chain) begin in_data = nd; in_valid = 1'b1; end
    tick();
    chk("R9 done pulse", tx_done, 1);
    chk("R9 ready with done", in_ready, 1);
    chk("R9 line high", txd, 1);
    chk("R9 xck at rest", xck, pol);
    @(negedge clk);
    if (chain) begin
      in_valid = 1'b0;
      chk("R2 accepted in done cycle", in_ready, 0);
    end else begin
      chk("R2 idle ready", in_ready, 1);
    end
    chk("R9 done single cycle", tx_done, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [0:5];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h6E;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset ready", in_ready, 1);
    chk("R1 reset done", tx_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle xck pol0", xck, 0);
    cfg_pol = 1'b1;
    @(negedge clk);
    chk("R1 idle xck pol1", xck, 1);
    tick();
    chk("R7 tick while idle", txd, 1);
    chk("R1 tick while idle done", tx_done, 0);
    for (int c = 0; c < 32; c++)
      for (int p = 0; p < 6; p++)
        send(pats[p], 5'(c), 0, 0, 8'h00);
    // Back-to-back: next character accepted in the completion cycle
    for (int c = 0; c < 32; c += 5) begin
      send(8'hC9, 5'(c), 0, 1, 8'h57);
      send(8'h57, 5'(c), 1, 0, 8'h00);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule